// File: doc/BRIEF.md
# System Control Register Bank with Access Traps

This block is a small set of memory-mapped system control registers that also acts on the data path beside it. Software programs it through a simple register bus: an address, write data, a write strobe and a combinational read-data return. Three kinds of state come out of it. A trap enable guards the lowest 4 KiB of physical memory. A mask word gives one bit per core to gate that core's fast interrupt. An overlay enable and a 32-bit overlay word replace data reads of the boot ROM.

Alongside the register bus, the block watches a stream of memory accesses. Each access has a valid bit, a physical address and a kind code. When the trap is armed, the block raises a trap flag for loads and stores into the low page. When the overlay is armed, it substitutes the overlay word for the ROM data on loads that fall in the ROM window. Both paths are combinational from the access inputs to the outputs. Register writes take effect from the cycle after the write strobe.

A read-only capability word reports which operating modes the chip supports. Its value is fixed by a parameter.

Top module: `sysctl_trap_bank`

## Requirements
- R1: After reset, the registers read as follows: the trap control register (offset 0x00) reads 0x00010000, the core mask (offset 0x04) reads 0xF, the overlay enable (offset 0x08) reads 0, the overlay word (offset 0x0C) reads 0, and the capability word (offset 0x10) reads the CAP_WORD parameter.
- R2: A write with reg_we high updates the addressed register at the next rising clock edge, and the new value is visible from then on. Only these bits are stored: bits 0 and 16 of the trap control register, bits 0..NUM_CORES-1 of the core mask, bit 0 of the overlay enable, and all 32 bits of the overlay word. Every other bit reads as zero.
- R3: When trap control bit 0 is set, a valid access of kind load (1) or store (2) with address 0x0000..0x0FFF drives acc_trap high in the same cycle.
- R4: acc_trap stays low in each of these cases: the kind is fetch (0) or reserved (3), the address is 0x1000 or above, trap control bit 0 is clear, or acc_valid is low.
- R5: fiq_mask bit n equals bit n of the core mask register. A set bit masks core n's fast interrupt.
- R6: When the overlay enable bit 0 is set, a valid load whose address lies in [ROM_BASE, ROM_BASE+ROM_SIZE) drives rd_data_out to the overlay word and overlay_hit high in the same cycle.
- R7: In every other case, rd_data_out equals rom_rdata_in and overlay_hit is low. This covers stores, fetches, reserved kinds, addresses outside the window, a disabled overlay and an invalid access.
- R8: Writes to the capability word are ignored. It keeps reading CAP_WORD, with bit 0 for base mode, bit 1 for the first extended mode and bit 2 for the second extended mode.
- R9: Offsets other than the five above read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| acc_valid | input | 1 | Monitored access is present |
| acc_addr | input | 32 | Physical address of the monitored access |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 reserved |
| acc_trap | output | 1 | Access must trap (low page) |
| rom_rdata_in | input | 32 | Data returned by the boot ROM |
| rd_data_out | output | 32 | Read data after overlay substitution |
| overlay_hit | output | 1 | Overlay word is substituted this cycle |
| fiq_mask | output | NUM_CORES | Per-core fast-interrupt mask |

## Verification
A corrupted trap enable or overlay enable shows up on acc_trap, overlay_hit and rd_data_out in the same cycle as the next access that reaches the affected address range. The bench therefore mixes random addresses around the 0x1000 edge and around both edges of the ROM window with all four access kinds. A wrong mask or overlay word appears at fiq_mask or rd_data_out one cycle after the write that set it. Lost or stray register bits are exposed by reading back every offset after writes of all ones.

// File: rtl/sysctl_pkg.sv
// Package: shared offsets, access kinds and bit masks of the system control bank.
// Assumes word-aligned register offsets on an 8-bit byte address.
package sysctl_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam int          REG_AW      = 8;
    localparam logic [7:0]  OFS_TRAP    = 8'h00;
    localparam logic [7:0]  OFS_FIQ     = 8'h04;
    localparam logic [7:0]  OFS_OVL_EN  = 8'h08;
    localparam logic [7:0]  OFS_OVL_VAL = 8'h0C;
    localparam logic [7:0]  OFS_CAP     = 8'h10;

    localparam logic [31:0] TRAP_KEEP   = 32'h0001_0001;
    localparam logic [31:0] TRAP_INIT   = 32'h0001_0000;
endpackage

// File: rtl/sysctl_regfile.sv
// Module: register storage and read mux of the system control bank.
// Holds the trap control, core mask, overlay enable and overlay word.
// The capability word is a parameter. Writes land on the clock edge
// where reg_we is high. Reads are combinational.
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          NUM_CORES = 4,
    parameter int          CAP_BITS  = 3,
    parameter logic [CAP_BITS-1:0] CAP_WORD = 3'b111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              trap_en,
    output logic [NUM_CORES-1:0] fiq_q,
    output logic              ovl_en,
    output logic [DATA_W-1:0] ovl_val
);
    localparam int FIQ_PAD = DATA_W - NUM_CORES;
    localparam int CAP_PAD = DATA_W - CAP_BITS;

    logic [DATA_W-1:0] trap_q;
    logic              wr_trap, wr_fiq, wr_ovl_en, wr_ovl_val;

    // Decode which register the current write targets.
    always_comb begin
        wr_trap    = reg_we && (reg_addr == OFS_TRAP);
        wr_fiq     = reg_we && (reg_addr == OFS_FIQ);
        wr_ovl_en  = reg_we && (reg_addr == OFS_OVL_EN);
        wr_ovl_val = reg_we && (reg_addr == OFS_OVL_VAL);
    end

    // Trap control: keep only the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       trap_q <= TRAP_INIT[DATA_W-1:0];
        else if (wr_trap) trap_q <= reg_wdata & TRAP_KEEP[DATA_W-1:0];
    end

    // One mask flop per core, reset to masked.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_mask
        always_ff @(posedge clk) begin
            if (!rst_n)      fiq_q[c] <= 1'b1;
            else if (wr_fiq) fiq_q[c] <= reg_wdata[c];
        end
    end

    // Overlay enable and the overlay word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovl_en  <= 1'b0;
            ovl_val <= '0;
        end else begin
            if (wr_ovl_en)  ovl_en  <= reg_wdata[0];
            if (wr_ovl_val) ovl_val <= reg_wdata;
        end
    end

    assign trap_en = trap_q[0];

    // Read mux: unmapped offsets and unused bits read as zero.
    always_comb begin
        unique case (reg_addr)
            OFS_TRAP:    reg_rdata = trap_q;
            OFS_FIQ:     reg_rdata = {{FIQ_PAD{1'b0}}, fiq_q};
            OFS_OVL_EN:  reg_rdata = {{(DATA_W-1){1'b0}}, ovl_en};
            OFS_OVL_VAL: reg_rdata = ovl_val;
            OFS_CAP:     reg_rdata = {{CAP_PAD{1'b0}}, CAP_WORD};
            default:     reg_rdata = '0;
        endcase
    end

    // R1: the first cycle out of reset sees every core masked.
    p_mask_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (fiq_q == {NUM_CORES{1'b1}}));

    // R2: a mask write shows up on the next cycle.
    p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_fiq)) |-> (fiq_q == $past(reg_wdata[NUM_CORES-1:0])));

    // R8: the capability word never changes on the bus.
    p_cap_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_CAP) |-> (reg_rdata[CAP_BITS-1:0] == CAP_WORD));
endmodule

// File: rtl/sysctl_null_trap.sv
// Module: low-page trap detector.
// Flags loads and stores below PAGE_LIMIT while the trap is armed.
// Fetches and reserved kinds pass through. The path is purely
// combinational; clk and rst_n serve only the assertions.
module sysctl_null_trap
    import sysctl_pkg::*;
#(
    parameter int              PA_W       = 32,
    parameter logic [PA_W-1:0] PAGE_LIMIT = 'h1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_en,
    input  logic            acc_valid,
    input  logic [PA_W-1:0] acc_addr,
    input  logic [1:0]      acc_kind,
    output logic            acc_trap
);
    logic is_data, in_page;

    // Classify the access and raise the trap.
    always_comb begin
        is_data  = (acc_kind == ACC_LOAD) || (acc_kind == ACC_STORE);
        in_page  = (acc_addr < PAGE_LIMIT);
        acc_trap = trap_en && acc_valid && is_data && in_page;
    end

    // R4: instruction fetches never trap.
    p_fetch_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == ACC_FETCH) |-> !acc_trap);

    // R4: addresses at or above the page limit never trap.
    p_high_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr >= PAGE_LIMIT) |-> !acc_trap);
endmodule

// File: rtl/sysctl_rom_overlay.sv
// Module: boot-ROM read overlay.
// Replaces ROM data with the overlay word on valid loads inside
// [ROM_BASE, ROM_BASE+ROM_SIZE) while the overlay is enabled. The path
// is combinational; clk and rst_n serve only the assertions.
module sysctl_rom_overlay
    import sysctl_pkg::*;
#(
    parameter int              PA_W     = 32,
    parameter int              DATA_W   = 32,
    parameter logic [PA_W-1:0] ROM_BASE = 'h0001_0000,
    parameter logic [PA_W-1:0] ROM_SIZE = 'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovl_en,
    input  logic [DATA_W-1:0] ovl_val,
    input  logic              acc_valid,
    input  logic [PA_W-1:0]   acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic [DATA_W-1:0] rom_rdata_in,
    output logic [DATA_W-1:0] rd_data_out,
    output logic              overlay_hit
);
    localparam logic [PA_W:0] ROM_END = {1'b0, ROM_BASE} + {1'b0, ROM_SIZE};

    logic in_rom;

    // Window check and data substitution.
    always_comb begin
        in_rom      = (acc_addr >= ROM_BASE) && ({1'b0, acc_addr} < ROM_END);
        overlay_hit = ovl_en && acc_valid && (acc_kind == ACC_LOAD) && in_rom;
        rd_data_out = overlay_hit ? ovl_val : rom_rdata_in;
    end

    // R6: a hit always returns the programmed word.
    p_hit_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overlay_hit |-> (rd_data_out == ovl_val));

    // R7: stores are never substituted.
    p_store_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == ACC_STORE) |-> (rd_data_out == rom_rdata_in));
endmodule

// File: rtl/sysctl_trap_bank.sv
// Module: top of the system control bank.
// Joins the register file, the low-page trap and the ROM overlay.
// Assumes a single clock and a synchronous active-low reset.
module sysctl_trap_bank
    import sysctl_pkg::*;
#(
    parameter int                   DATA_W     = 32,
    parameter int                   PA_W       = 32,
    parameter int                   NUM_CORES  = 4,
    parameter int                   CAP_BITS   = 3,
    parameter logic [CAP_BITS-1:0]  CAP_WORD   = 3'b111,
    parameter logic [PA_W-1:0]      PAGE_LIMIT = 'h1000,
    parameter logic [PA_W-1:0]      ROM_BASE   = 'h0001_0000,
    parameter logic [PA_W-1:0]      ROM_SIZE   = 'h0001_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 reg_we,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 acc_valid,
    input  logic [PA_W-1:0]      acc_addr,
    input  logic [1:0]           acc_kind,
    output logic                 acc_trap,
    input  logic [DATA_W-1:0]    rom_rdata_in,
    output logic [DATA_W-1:0]    rd_data_out,
    output logic                 overlay_hit,
    output logic [NUM_CORES-1:0] fiq_mask
);
    logic              trap_en;
    logic              ovl_en;
    logic [DATA_W-1:0] ovl_val;

    sysctl_regfile #(
        .DATA_W(DATA_W), .NUM_CORES(NUM_CORES),
        .CAP_BITS(CAP_BITS), .CAP_WORD(CAP_WORD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .trap_en(trap_en), .fiq_q(fiq_mask),
        .ovl_en(ovl_en), .ovl_val(ovl_val)
    );

    sysctl_null_trap #(.PA_W(PA_W), .PAGE_LIMIT(PAGE_LIMIT)) u_trap (
        .clk(clk), .rst_n(rst_n), .trap_en(trap_en),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
        .acc_trap(acc_trap)
    );

    sysctl_rom_overlay #(
        .PA_W(PA_W), .DATA_W(DATA_W), .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE)
    ) u_ovl (
        .clk(clk), .rst_n(rst_n), .ovl_en(ovl_en), .ovl_val(ovl_val),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
        .rom_rdata_in(rom_rdata_in), .rd_data_out(rd_data_out),
        .overlay_hit(overlay_hit)
    );
endmodule

// File: tb/tb_sysctl_trap_bank.sv
// Bench: directed corners plus seeded random accesses and writes,
// compared against a bench-side model of the registers.
module tb_sysctl_trap_bank;
    localparam logic [31:0] ROM_BASE = 32'h0001_0000;
    localparam logic [31:0] ROM_SIZE = 32'h0001_0000;
    localparam logic [32:0] ROM_END  = 33'h0_0002_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic [1:0]  acc_kind = 2'd0;
    logic        acc_trap;
    logic [31:0] rom_rdata_in = 32'h0;
    logic [31:0] rd_data_out;
    logic        overlay_hit;
    logic [3:0]  fiq_mask;

    int tests = 0;
    int fails = 0;

    logic [31:0] m_trap, m_ovl_val;
    logic [3:0]  m_fiq;
    logic        m_ovl_en;

    always #2 clk = ~clk;

    sysctl_trap_bank dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_trap(acc_trap),
        .rom_rdata_in(rom_rdata_in), .rd_data_out(rd_data_out),
        .overlay_hit(overlay_hit), .fiq_mask(fiq_mask)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_trap;
            8'h04:   return {28'h0, m_fiq};
            8'h08:   return {31'h0, m_ovl_en};
            8'h0C:   return m_ovl_val;
            8'h10:   return 32'h7;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic exp_trap(input logic v, input logic [31:0] a, input logic [1:0] k);
        return m_trap[0] && v && (k == 2'd1 || k == 2'd2) && (a < 32'h1000);
    endfunction

    function automatic logic exp_hit(input logic v, input logic [31:0] a, input logic [1:0] k);
        return m_ovl_en && v && (k == 2'd1) && (a >= ROM_BASE) && ({1'b0, a} < ROM_END);
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h00: m_trap = d & 32'h0001_0001;
            8'h04: m_fiq = d[3:0];
            8'h08: m_ovl_en = d[0];
            8'h0C: m_ovl_val = d;
            default: ;
        endcase
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic reg_check(input string req, input logic [7:0] a);
        @(negedge clk);
        reg_addr = a;
        #1 chk(req, reg_rdata, model_read(a));
    endtask

    task automatic acc_check(input string rq_t, input string rq_d, input logic v,
                             input logic [31:0] a, input logic [1:0] k, input logic [31:0] rom);
        logic h;
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_kind = k; rom_rdata_in = rom;
        #1;
        h = exp_hit(v, a, k);
        chk(rq_t, {31'h0, acc_trap}, {31'h0, exp_trap(v, a, k)});
        chk(rq_d, {31'h0, overlay_hit}, {31'h0, h});
        chk(rq_d, rd_data_out, h ? m_ovl_val : rom);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        m_trap = 32'h0001_0000; m_fiq = 4'hF; m_ovl_en = 1'b0; m_ovl_val = 32'h0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values of every register
        reg_check("R1", 8'h00); reg_check("R1", 8'h04); reg_check("R1", 8'h08);
        reg_check("R1", 8'h0C); reg_check("R1", 8'h10);
        chk("R1", {28'h0, fiq_mask}, 32'hF);

        // R4: trap disarmed at reset, low page load does not trap
        acc_check("R4", "R7", 1'b1, 32'h0000_0010, 2'd1, 32'hAAAA_5555);

        // R2: write timing, new value is not visible before the edge
        @(negedge clk);
        reg_addr = 8'h04; reg_wdata = 32'h5; reg_we = 1'b1;
        #1 chk("R2", {28'h0, fiq_mask}, 32'hF);
        @(negedge clk);
        reg_we = 1'b0; model_write(8'h04, 32'h5);
        chk("R5", {28'h0, fiq_mask}, 32'h5);

        // R2: unused bits read as zero after all-ones writes
        reg_write(8'h00, 32'hFFFF_FFFF); reg_check("R2", 8'h00);
        reg_write(8'h04, 32'hFFFF_FFFF); reg_check("R2", 8'h04);
        reg_write(8'h08, 32'hFFFF_FFFF); reg_check("R2", 8'h08);
        reg_write(8'h0C, 32'hDEAD_BEEF); reg_check("R2", 8'h0C);

        // R8: capability word ignores writes
        reg_write(8'h10, 32'h0); reg_check("R8", 8'h10);

        // R9: unmapped offsets read zero and writes there change nothing
        reg_write(8'h14, 32'hFFFF_FFFF); reg_check("R9", 8'h14);
        reg_write(8'h02, 32'h0); reg_check("R9", 8'h02);
        reg_check("R9", 8'h00); reg_check("R9", 8'h04);
        reg_check("R9", 8'h08); reg_check("R9", 8'h0C);

        // R3 / R4: low-page boundary and kinds
        acc_check("R3", "R7", 1'b1, 32'h0000_0FFF, 2'd1, 32'h1);
        acc_check("R3", "R7", 1'b1, 32'h0000_0000, 2'd2, 32'h2);
        acc_check("R4", "R7", 1'b1, 32'h0000_1000, 2'd1, 32'h3);
        acc_check("R4", "R7", 1'b1, 32'h0000_0000, 2'd0, 32'h4);
        acc_check("R4", "R7", 1'b1, 32'h0000_0004, 2'd3, 32'h5);
        acc_check("R4", "R7", 1'b0, 32'h0000_0004, 2'd1, 32'h6);

        // R6 / R7: ROM window edges
        acc_check("R4", "R6", 1'b1, ROM_BASE, 2'd1, 32'h7);
        acc_check("R4", "R6", 1'b1, ROM_BASE + ROM_SIZE - 1, 2'd1, 32'h8);
        acc_check("R4", "R7", 1'b1, ROM_BASE - 1, 2'd1, 32'h9);
        acc_check("R4", "R7", 1'b1, ROM_BASE + ROM_SIZE, 2'd1, 32'hA);
        acc_check("R4", "R7", 1'b1, ROM_BASE + 32'h40, 2'd2, 32'hB);
        acc_check("R4", "R7", 1'b1, ROM_BASE + 32'h40, 2'd0, 32'hC);
        reg_write(8'h08, 32'h0);
        acc_check("R4", "R7", 1'b1, ROM_BASE + 32'h40, 2'd1, 32'hD);

        // Random mix of register writes and accesses
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            int sel;
            if ($urandom_range(0, 7) == 0) begin
                logic [7:0] off;
                off = 8'(4 * $urandom_range(0, 5));
                reg_write(off, $urandom());
                reg_check("R2", off);
                chk("R5", {28'h0, fiq_mask}, {28'h0, m_fiq});
            end
            sel = $urandom_range(0, 3);
            case (sel)
                0: a = 32'(32'h0000_0F00 + $urandom_range(0, 32'h1FF));
                1: a = 32'(ROM_BASE - 8 + $urandom_range(0, 16));
                2: a = 32'(ROM_BASE + ROM_SIZE - 8 + $urandom_range(0, 16));
                default: a = $urandom();
            endcase
            acc_check("R3", "R6", 1'($urandom_range(0, 7) != 0), a,
                      2'($urandom_range(0, 3)), $urandom());
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule